// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block turns a 64-bit command word into a single read-modify-write of one 32-bit word in a target core's register space. A sender presents the command together with its write offset and an indication that the access is 8 bytes wide. Two command offsets are recognised. One aims at a fixed mailbox area, choosing one of eight word slots. The other carries a free 16-bit target address. Both take the target core number from the command. Both carry the replacement data in the upper half of the command.

A four-bit preserve mask in the command names the bytes of the existing word that must survive. When any preserve bit is set, the block first reads the old word through its memory-request port. It then keeps the marked bytes and fills the others from the new data before writing the word back. When no preserve bit is set, the read is skipped and the new data is written at once. A command with an unknown core number is refused with a one-cycle error pulse. While a command is in flight the block does not accept another.

Top module: `mbx_remote_writer`

## Requirements
- R1: Only bits 11:0 of `cmd_addr` are compared against the command offsets. Bits 15:12 have no effect, so a write at 0xA048 acts as a mailbox command.
- R2: Only a wide (8-byte) write at offset 0x048 (mailbox command) or 0x158 (free-address command) acts. A narrow write, or a write at any other offset, issues no memory request and raises no error.
- R3: The target core number is command bits 25:16 and is driven on `req_core`. A number of NUM_CORES or more raises `err` for exactly one cycle, in the cycle after acceptance, and issues no memory request.
- R4: Command bits 30:27 are the preserve mask. When any of them is set, exactly one read of the target word is issued before the write. The written word keeps each preserved byte from the read data and takes every other byte from command bits 63:32.
- R5: When bits 30:27 are all zero, no read is issued and the written word equals command bits 63:32.
- R6: For the mailbox command the target address is MBOX_BASE + 0x20 + (command bits 15:0 AND 0x1C). Bits 1:0 and 15:5 of the command are ignored.
- R7: For the free-address command the target address is command bits 15:0.
- R8: Byte i is bits 8i+7:8i of both the old word and the written word, and preserve bit 27+i guards byte i.
- R9: `cmd_ready` is low from the cycle after a command is accepted until the write request has been accepted. Commands offered meanwhile wait.
- R10: A memory request that is not yet accepted keeps `req_valid` high, with its address and direction unchanged, until `req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_addr | input | 16 | Command write offset (low 12 bits decoded) |
| cmd_wide | input | 1 | Access is 8 bytes wide |
| cmd_data | input | 64 | Command word |
| err | output | 1 | One-cycle pulse for an unknown core number |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_we | output | 1 | 1 = write, 0 = read |
| req_core | output | CORE_W | Target core number |
| req_addr | output | 16 | Target word address |
| req_wdata | output | 32 | Merged write data |
| rsp_valid | input | 1 | Read data returned |
| rsp_rdata | input | 32 | Read data |

## Verification
The main function is tried with four preserve patterns: an empty mask, alternating bytes, a single top byte, and a full mask. These separate the skipped-read path, the per-byte lane order, and the case where the old word survives whole. Both command offsets are used, with junk in the ignored low bits and in the upper address bits, so that the two address formations and the 12-bit decode can be told apart. Narrow and off-offset writes, and core numbers just past and far past the limit, are mixed in. The same commands are then replayed with a memory port that accepts only every third cycle, which separates the handshake holding from the back-to-back acceptance rule.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int TGT_AW  = 16;
  localparam int WORD_W  = 32;
  localparam int NBYTES  = WORD_W / 8;
  localparam int CMD_W   = 64;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR      = 2'd3
  } mbx_state_e;

  // mailbox slot: base + 0x20 + word offset picked by command bits 4:2
  function automatic logic [TGT_AW-1:0] mail_slot_addr(
      input logic [TGT_AW-1:0] base,
      input logic [CMD_W-1:0]  cmd);
    mail_slot_addr = base + 16'h0020 + (cmd[TGT_AW-1:0] & 16'h001C);
  endfunction

  // preserve bits live at 27+i for byte i
  function automatic logic [NBYTES-1:0] keep_field(input logic [CMD_W-1:0] cmd);
    keep_field = cmd[27 +: NBYTES];
  endfunction
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import mbx_pkg::*;
#(
  parameter int                NUM_CORES = 4,
  parameter int                CORE_W    = 2,
  parameter logic [11:0]       MAIL_OFS  = 12'h048,
  parameter logic [11:0]       ANY_OFS   = 12'h158,
  parameter logic [TGT_AW-1:0] MBOX_BASE = 16'h1000
) (
  input  logic [TGT_AW-1:0] cmd_addr,
  input  logic              cmd_wide,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              hit,
  output logic              id_ok,
  output logic [CORE_W-1:0] core,
  output logic [NBYTES-1:0] keep,
  output logic [TGT_AW-1:0] tgt_addr,
  output logic [WORD_W-1:0] new_word
);
  localparam int ID_W = 10;

  logic [11:0]     ofs;
  logic            is_mail;
  logic            is_any;
  logic [ID_W-1:0] id;
  logic            unused_bits;

  assign ofs      = cmd_addr[11:0];
  assign is_mail  = cmd_wide && (ofs == MAIL_OFS);
  assign is_any   = cmd_wide && (ofs == ANY_OFS);
  assign hit      = is_mail || is_any;
  assign id       = cmd_data[16 +: ID_W];
  assign id_ok    = ({22'd0, id} < NUM_CORES);
  assign core     = id[CORE_W-1:0];
  assign keep     = keep_field(cmd_data);
  assign new_word = cmd_data[CMD_W-1 -: WORD_W];
  assign tgt_addr = is_mail ? mail_slot_addr(MBOX_BASE, cmd_data)
                            : cmd_data[TGT_AW-1:0];

  assign unused_bits = ^{cmd_addr[TGT_AW-1:12], cmd_data[26], cmd_data[31]};
endmodule

// File: rtl/mbx_merge.sv
module mbx_merge
  import mbx_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [NBYTES-1:0] keep,
  output logic [WORD_W-1:0] merged
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign merged[8*b +: 8] = keep[b] ? old_word[8*b +: 8] : new_word[8*b +: 8];
  end
endmodule

// File: rtl/mbx_rmw_fsm.sv
module mbx_rmw_fsm
  import mbx_pkg::*;
#(
  parameter int CORE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bad,
  input  logic [CORE_W-1:0] in_core,
  input  logic [TGT_AW-1:0] in_addr,
  input  logic [NBYTES-1:0] in_keep,
  input  logic [WORD_W-1:0] in_word,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_rdata,
  output logic              idle,
  output logic              err,
  output logic              req_valid,
  output logic              req_we,
  output logic [CORE_W-1:0] req_core,
  output logic [TGT_AW-1:0] req_addr,
  output logic [WORD_W-1:0] old_word,
  output logic [WORD_W-1:0] new_word,
  output logic [NBYTES-1:0] keep
);
  mbx_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      err      <= 1'b0;
      req_core <= '0;
      req_addr <= '0;
      old_word <= '0;
      new_word <= '0;
      keep     <= '0;
    end else begin
      err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            req_core <= in_core;
            req_addr <= in_addr;
            new_word <= in_word;
            keep     <= in_keep;
            state    <= (|in_keep) ? ST_RD_REQ : ST_WR;
          end else if (bad) begin
            err <= 1'b1;
          end
        end
        ST_RD_REQ:  if (req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (rsp_valid) begin
            old_word <= rsp_rdata;
            state    <= ST_WR;
          end
        end
        ST_WR:      if (req_ready) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state == ST_IDLE);
  assign req_valid = (state == ST_RD_REQ) || (state == ST_WR);
  assign req_we    = (state == ST_WR);
endmodule

// File: rtl/mbx_remote_writer.sv
module mbx_remote_writer
  import mbx_pkg::*;
#(
  parameter int                NUM_CORES = 4,
  parameter logic [11:0]       MAIL_OFS  = 12'h048,
  parameter logic [11:0]       ANY_OFS   = 12'h158,
  parameter logic [TGT_AW-1:0] MBOX_BASE = 16'h1000,
  localparam int               CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_addr,
  input  logic              cmd_wide,
  input  logic [63:0]       cmd_data,
  output logic              err,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [CORE_W-1:0] req_core,
  output logic [15:0]       req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_rdata
);
  logic              dec_hit;
  logic              dec_id_ok;
  logic [CORE_W-1:0] dec_core;
  logic [NBYTES-1:0] dec_keep;
  logic [TGT_AW-1:0] dec_addr;
  logic [WORD_W-1:0] dec_word;

  // named events for the checker
  logic              cmd_take;
  logic              cmd_go;
  logic              cmd_bad;
  logic              go_keep_any;

  logic [WORD_W-1:0] old_q;
  logic [WORD_W-1:0] new_q;
  logic [NBYTES-1:0] keep_q;

  mbx_cmd_decode #(
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W),
    .MAIL_OFS  (MAIL_OFS),
    .ANY_OFS   (ANY_OFS),
    .MBOX_BASE (MBOX_BASE)
  ) u_dec (
    .cmd_addr (cmd_addr),
    .cmd_wide (cmd_wide),
    .cmd_data (cmd_data),
    .hit      (dec_hit),
    .id_ok    (dec_id_ok),
    .core     (dec_core),
    .keep     (dec_keep),
    .tgt_addr (dec_addr),
    .new_word (dec_word)
  );

  assign cmd_take    = cmd_valid && cmd_ready;
  assign cmd_go      = cmd_take && dec_hit && dec_id_ok;
  assign cmd_bad     = cmd_take && dec_hit && !dec_id_ok;
  assign go_keep_any = |dec_keep;

  mbx_rmw_fsm #(.CORE_W(CORE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_go),
    .bad       (cmd_bad),
    .in_core   (dec_core),
    .in_addr   (dec_addr),
    .in_keep   (dec_keep),
    .in_word   (dec_word),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .idle      (cmd_ready),
    .err       (err),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_core  (req_core),
    .req_addr  (req_addr),
    .old_word  (old_q),
    .new_word  (new_q),
    .keep      (keep_q)
  );

  mbx_merge u_merge (
    .old_word (old_q),
    .new_word (new_q),
    .keep     (keep_q),
    .merged   (req_wdata)
  );
endmodule

// File: rtl/mbx_remote_writer_chk.sv
module mbx_remote_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        err,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_we,
  input logic [15:0] req_addr,
  input logic        cmd_go,
  input logic        go_keep_any
);
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R3
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !req_valid); // R3
  AST_KEEP_READS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && go_keep_any) |=> (req_valid && !req_we)); // R4
  AST_NOKEEP_WRITES_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !go_keep_any) |=> (req_valid && req_we)); // R5
  AST_BUSY_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready); // R9
  AST_READY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_ready) |=> cmd_ready); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_we) && $stable(req_addr))); // R10
endmodule

bind mbx_remote_writer mbx_remote_writer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready   (cmd_ready),
  .err         (err),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_we      (req_we),
  .req_addr    (req_addr),
  .cmd_go      (cmd_go),
  .go_keep_any (go_keep_any)
);

// File: tb/mbx_remote_writer_tb.sv
module mbx_remote_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_addr = '0;
  logic        cmd_wide = 1'b0;
  logic [63:0] cmd_data = '0;
  logic        err;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic        req_we;
  logic [1:0]  req_core;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  always #2.5 clk = ~clk;

  mbx_remote_writer u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_wide(cmd_wide), .cmd_data(cmd_data), .err(err),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  typedef struct {
    int          core;
    logic [15:0] addr;
    logic [31:0] data;
  } exp_t;

  exp_t wq[$];
  exp_t rq[$];
  int   n_total = 0;
  int   n_pass  = 0;
  bit   stall   = 1'b0;
  bit   done    = 1'b0;
  int   cyc     = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s act=%h exp=%h", tag, act, exp);
  endtask

  function automatic logic [31:0] old_model(input int core, input logic [15:0] a);
    return {a ^ 16'h3C5A, 8'hC3 ^ 8'(core), 8'h96};
  endfunction

  function automatic logic [63:0] mk(input logic [9:0] id, input logic [3:0] keep,
                                     input logic [31:0] hi, input logic [15:0] lo);
    return {hi, 1'b1, keep, 1'b1, id, lo};
  endfunction

  // memory model and monitor
  initial begin
    bit          pend = 1'b0;
    logic [31:0] pend_d = '0;
    exp_t        e;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = pend;
      rsp_rdata = pend_d;
      pend      = 1'b0;
      req_ready = !stall || (cyc % 3 == 0);
      if (rst_n && req_valid && req_ready) begin
        if (req_we) begin
          if (wq.size() == 0) chk(1'b0, "R2/R3 unexpected write", {32'd0, req_wdata}, 64'd0);
          else begin
            e = wq.pop_front();
            chk(int'(req_core) == e.core && req_addr == e.addr && req_wdata == e.data,
                "R4/R5/R6/R7/R8 write core,addr,data",
                {8'(req_core), 8'd0, req_addr, req_wdata}, {8'(e.core), 8'd0, e.addr, e.data});
          end
        end else begin
          if (rq.size() == 0) chk(1'b0, "R5 unexpected read", {48'd0, req_addr}, 64'd0);
          else begin
            e = rq.pop_front();
            chk(int'(req_core) == e.core && req_addr == e.addr, "R4 read core,addr",
                {8'(req_core), 40'd0, req_addr}, {8'(e.core), 40'd0, e.addr});
          end
          pend   = 1'b1;
          pend_d = old_model(int'(req_core), req_addr);
        end
      end
    end
  end

  task automatic send(input logic [15:0] a, input bit wide, input logic [63:0] d);
    bit          mail, anyc, good, bad;
    int          id;
    logic [3:0]  keep;
    logic [15:0] ta;
    logic [31:0] old, nw;
    exp_t        e;
    mail = wide && (a[11:0] == 12'h048);
    anyc = wide && (a[11:0] == 12'h158);
    id   = int'(d[25:16]);
    keep = d[30:27];
    good = (mail || anyc) && id < 4;
    bad  = (mail || anyc) && id >= 4;
    if (good) begin
      ta  = mail ? (16'h1020 + (d[15:0] & 16'h001C)) : d[15:0];
      old = old_model(id, ta);
      for (int i = 0; i < 4; i++)
        nw[8*i +: 8] = keep[i] ? old[8*i +: 8] : d[32 + 8*i +: 8];
      e.core = id; e.addr = ta; e.data = nw;
      if (keep != 4'd0) rq.push_back(e);
      wq.push_back(e);
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_wide = wide; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (good) begin
      chk(!cmd_ready, "R9 busy after accept", {63'd0, cmd_ready}, 64'd0);
      chk(!err, "R3 no error on known core", {63'd0, err}, 64'd0);
    end else if (bad) begin
      chk(err, "R3 error pulse", {63'd0, err}, 64'd1);
      chk(cmd_ready, "R3 stays idle on error", {63'd0, cmd_ready}, 64'd1);
      @(negedge clk);
      chk(!err, "R3 error lasts one cycle", {63'd0, err}, 64'd0);
    end else begin
      chk(!err && cmd_ready, "R2 ignored command", {62'd0, err, cmd_ready}, 64'd1);
    end
  endtask

  task automatic run_set();
    send(16'h0048, 1'b1, mk(10'd1, 4'b0000, 32'hDEADBEEF, 16'hFFEC));   // R5 R6 slot 0x0C
    send(16'h0048, 1'b1, mk(10'd2, 4'b0101, 32'h11223344, 16'h001F));   // R4 R8 slot 0x1C
    send(16'h0158, 1'b1, mk(10'd3, 4'b1111, 32'hCAFEF00D, 16'h1234));   // R4 R7 full keep
    send(16'h0158, 1'b1, mk(10'd0, 4'b1000, 32'hA1B2C3D4, 16'h0F00));   // R8 top byte
    send(16'hF158, 1'b1, mk(10'd1, 4'b0000, 32'h0BADC0DE, 16'h8004));   // R1
    send(16'hA048, 1'b1, mk(10'd3, 4'b0010, 32'h55667788, 16'h0003));   // R1 R6
    send(16'h0048, 1'b0, mk(10'd1, 4'b0000, 32'h12345678, 16'h0000));   // R2 narrow
    send(16'h0050, 1'b1, mk(10'd1, 4'b0000, 32'h12345678, 16'h0000));   // R2 offset
    send(16'h0048, 1'b1, mk(10'd4, 4'b0000, 32'h99999999, 16'h0000));   // R3 just past
    send(16'h0158, 1'b1, mk(10'h3FF, 4'b0011, 32'h99999999, 16'h0000)); // R3 far past
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready, "R9 ready after reset", {63'd0, cmd_ready}, 64'd1);
    chk(!req_valid, "R10 no request after reset", {63'd0, req_valid}, 64'd0);
    chk(!err, "R3 no error after reset", {63'd0, err}, 64'd0);
    rst_n = 1'b1;
    run_set();
    stall = 1'b1;
    run_set();
    while (wq.size() != 0 || !cmd_ready) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(wq.size() == 0 && rq.size() == 0, "R4/R5 all expected requests seen",
        64'(wq.size() + rq.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R9 watchdog expired", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end
endmodule